// File: doc/BRIEF.md
# SCSI Initiator Command Decoder

This block sits behind the command register of a SCSI initiator controller. Each byte written there is split into a DMA-mode bit and a seven-bit opcode. The opcode is decoded into fixed updates of the controller's status, interrupt-reason and sequence-step registers. The block also produces one-cycle start pulses for the transfer engine, the chip-reset logic, the FIFO-flag clear and the transfer-count reload.

The bus itself, the attached devices and the SCSI command set are outside the block. Device presence arrives as a bitmap indexed by the target ID field. The bus-reset interrupt suppression bit arrives from the configuration register. The interrupt is a sticky flag. A command raises it, and an acknowledge input (the read of the interrupt-reason register) lowers it.

All register updates take effect on the clock edge that samples the write. Pulses are high for exactly the following cycle.

Top module: `scsi_cmd_decoder`

## Requirements
- R1: On a write, `dmaMode` takes command bit 7. When bit 7 is 1, `tcReload` pulses for one cycle. A chip-reset opcode leaves `dmaMode` at 0.
- R2: Opcode 0x01 (flush) sets the interrupt reason to 0x08 and the sequence step to 0, pulses `fifoFlagsClr`, and leaves the interrupt unchanged.
- R3: Opcode 0x02 (chip reset) clears status, interrupt reason, sequence step, interrupt, DMA mode, the wait-for-command-bytes flag and the command image, and pulses `chipRstPulse`.
- R4: Opcode 0x03 (bus reset) sets the interrupt reason to 0x80. It raises the interrupt only when `cfgBusRstQuiet` is 0.
- R5: Opcodes 0x42 and 0x43 (select) whose target `targetPresent[busId]` is 0 set status bits 6:0 to 0, the reason to 0x20 and the sequence step to 0, and raise the interrupt.
- R6: Opcode 0x42 with the target present sets the reason to 0x18 and the sequence step to 4, raises the interrupt, and leaves status bits 6:0 alone.
- R7: Opcode 0x43 with the target present does what R6 does. It also sets status bits 6:0 to 0x12 (terminal count bit 4, command phase 2 in bits 2:0) and sets `awaitCmdBytes`.
- R8: Opcode 0x10 (transfer information) pulses `xferStart` and clears `awaitCmdBytes`.
- R9: Opcode 0x11 (command-complete sequence) sets the reason to 0x08, ORs phase 7 into status bits 2:0 and raises the interrupt. Opcode 0x12 (message accepted) sets the reason to 0x20 and the step to 0, and raises the interrupt.
- R10: Opcode 0x44 clears the interrupt reason. Opcodes 0x00 and 0x1A change nothing but the command image and DMA mode.
- R11: Any other opcode pulses `badCmd` for one cycle. It changes nothing but the command image and DMA mode.
- R12: `irqAck` lowers the interrupt. If a command raises the interrupt in the same cycle, the interrupt stays set. Status bit 7 always equals `irq`.
- R13: Every write loads the full byte into `cmdImage`, except a chip reset, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWr | input | 1 | Command register write strobe |
| cmdByte | input | 8 | Byte written: bit 7 DMA, bits 6:0 opcode |
| busId | input | 3 | Target ID field for select commands |
| targetPresent | input | 8 | One bit per target ID, 1 = device attached |
| cfgBusRstQuiet | input | 1 | Configuration bit: suppress bus-reset interrupt |
| irqAck | input | 1 | Interrupt acknowledge (reason register read) |
| status | output | 8 | Status register: bit 7 interrupt, bit 4 terminal count, bits 2:0 phase |
| intReason | output | 8 | Interrupt-reason register |
| seqStep | output | 8 | Sequence-step register |
| irq | output | 1 | Interrupt request |
| dmaMode | output | 1 | DMA mode flag |
| tcReload | output | 1 | Transfer-count reload pulse |
| xferStart | output | 1 | Transfer engine start pulse |
| chipRstPulse | output | 1 | Chip reset pulse |
| fifoFlagsClr | output | 1 | FIFO-flags clear pulse |
| badCmd | output | 1 | Unknown-opcode pulse |
| awaitCmdBytes | output | 1 | Waiting for further command bytes after select-and-stop |
| cmdImage | output | 8 | Last command byte written |

## Verification
Two functions can land in the same cycle: the acknowledge that lowers the interrupt and a command that raises it. The bench drives `irqAck` in the same cycle as a command-complete write and expects the interrupt to stay set. It also drives the acknowledge together with a flush, which raises nothing, and expects the interrupt to fall. A behavioural model updates on every clock edge and is compared with every register and pulse output, so a wrong priority shows up in the cycle right after the collision.

// File: rtl/scsi_cmd_dec_pkg.sv
package scsi_cmd_dec_pkg;
  localparam int REG_W = 8;
  localparam int OP_W  = REG_W - 1;
  localparam int STS_W = REG_W - 1;

  localparam logic [OP_W-1:0] OP_NOP     = 7'h00;
  localparam logic [OP_W-1:0] OP_FLUSH   = 7'h01;
  localparam logic [OP_W-1:0] OP_CHIPRST = 7'h02;
  localparam logic [OP_W-1:0] OP_BUSRST  = 7'h03;
  localparam logic [OP_W-1:0] OP_XFER    = 7'h10;
  localparam logic [OP_W-1:0] OP_CMPLSEQ = 7'h11;
  localparam logic [OP_W-1:0] OP_MSGOK   = 7'h12;
  localparam logic [OP_W-1:0] OP_ATN     = 7'h1A;
  localparam logic [OP_W-1:0] OP_SEL     = 7'h42;
  localparam logic [OP_W-1:0] OP_SELSTOP = 7'h43;
  localparam logic [OP_W-1:0] OP_ENSEL   = 7'h44;

  localparam logic [REG_W-1:0] RSN_FUNC_DONE = 8'h08;
  localparam logic [REG_W-1:0] RSN_SVC_DONE  = 8'h18;
  localparam logic [REG_W-1:0] RSN_DISCON    = 8'h20;
  localparam logic [REG_W-1:0] RSN_BUSRST    = 8'h80;
  localparam logic [REG_W-1:0] STEP_CMD_DONE = 8'h04;
  localparam logic [STS_W-1:0] STS_TC_CMD    = 7'h12;
  localparam logic [STS_W-1:0] STS_PHASE_MI  = 7'h07;

  typedef struct packed {
    logic             ldReason;
    logic [REG_W-1:0] reasonVal;
    logic             ldSeq;
    logic [REG_W-1:0] seqVal;
    logic             ldStatus;
    logic [STS_W-1:0] statusVal;
    logic             orStatus;
    logic [STS_W-1:0] orVal;
    logic             raiseIrq;
    logic             chipRst;
    logic             xferGo;
    logic             fifoClr;
    logic             awaitSet;
    logic             awaitClr;
    logic             badOp;
  } decStrobes_t;
endpackage

// File: rtl/scsi_cmd_ctl.sv
module scsi_cmd_ctl
  import scsi_cmd_dec_pkg::*;
#(
  parameter int ID_W = 3,
  localparam int N_TGT = 1 << ID_W
) (
  input  logic              cmdWr,
  input  logic [OP_W-1:0]   opField,
  input  logic [ID_W-1:0]   busId,
  input  logic [N_TGT-1:0]  targetPresent,
  input  logic              cfgBusRstQuiet,
  output decStrobes_t       strb
);
  logic targetHere;
  assign targetHere = targetPresent[busId];

  always_comb begin
    strb = '0;
    if (cmdWr) begin
      case (opField)
        OP_NOP, OP_ATN: ;
        OP_FLUSH: begin
          strb.ldReason  = 1'b1;
          strb.reasonVal = RSN_FUNC_DONE;
          strb.ldSeq     = 1'b1;
          strb.seqVal    = '0;
          strb.fifoClr   = 1'b1;
        end
        OP_CHIPRST: strb.chipRst = 1'b1;
        OP_BUSRST: begin
          strb.ldReason  = 1'b1;
          strb.reasonVal = RSN_BUSRST;
          strb.raiseIrq  = !cfgBusRstQuiet;
        end
        OP_XFER: begin
          strb.xferGo   = 1'b1;
          strb.awaitClr = 1'b1;
        end
        OP_CMPLSEQ: begin
          strb.ldReason  = 1'b1;
          strb.reasonVal = RSN_FUNC_DONE;
          strb.orStatus  = 1'b1;
          strb.orVal     = STS_PHASE_MI;
          strb.raiseIrq  = 1'b1;
        end
        OP_MSGOK: begin
          strb.ldReason  = 1'b1;
          strb.reasonVal = RSN_DISCON;
          strb.ldSeq     = 1'b1;
          strb.seqVal    = '0;
          strb.raiseIrq  = 1'b1;
        end
        OP_SEL, OP_SELSTOP: begin
          strb.ldReason = 1'b1;
          strb.ldSeq    = 1'b1;
          strb.raiseIrq = 1'b1;
          if (!targetHere) begin
            strb.reasonVal = RSN_DISCON;
            strb.seqVal    = '0;
            strb.ldStatus  = 1'b1;
            strb.statusVal = '0;
          end else begin
            strb.reasonVal = RSN_SVC_DONE;
            strb.seqVal    = STEP_CMD_DONE;
            if (opField == OP_SELSTOP) begin
              strb.ldStatus  = 1'b1;
              strb.statusVal = STS_TC_CMD;
              strb.awaitSet  = 1'b1;
            end
          end
        end
        OP_ENSEL: begin
          strb.ldReason  = 1'b1;
          strb.reasonVal = '0;
        end
        default: strb.badOp = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/scsi_cmd_dp.sv
module scsi_cmd_dp
  import scsi_cmd_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [REG_W-1:0] cmdByte,
  input  logic             irqAck,
  input  decStrobes_t      strb,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] intReason,
  output logic [REG_W-1:0] seqStep,
  output logic             irq,
  output logic             dmaMode,
  output logic             tcReload,
  output logic             xferStart,
  output logic             chipRstPulse,
  output logic             fifoFlagsClr,
  output logic             badCmd,
  output logic             awaitCmdBytes,
  output logic [REG_W-1:0] cmdImage
);
  logic [STS_W-1:0] stsLow;
  assign status = {irq, stsLow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsLow        <= '0;
      intReason     <= '0;
      seqStep       <= '0;
      irq           <= 1'b0;
      dmaMode       <= 1'b0;
      tcReload      <= 1'b0;
      xferStart     <= 1'b0;
      chipRstPulse  <= 1'b0;
      fifoFlagsClr  <= 1'b0;
      badCmd        <= 1'b0;
      awaitCmdBytes <= 1'b0;
      cmdImage      <= '0;
    end else begin
      tcReload     <= cmdWr & cmdByte[REG_W-1];
      xferStart    <= strb.xferGo;
      chipRstPulse <= strb.chipRst;
      fifoFlagsClr <= strb.fifoClr;
      badCmd       <= strb.badOp;
      if (cmdWr) begin
        dmaMode  <= cmdByte[REG_W-1];
        cmdImage <= cmdByte;
      end
      if (irqAck)        irq <= 1'b0;
      if (strb.raiseIrq) irq <= 1'b1;
      if (strb.ldReason) intReason <= strb.reasonVal;
      if (strb.ldSeq)    seqStep <= strb.seqVal;
      if (strb.ldStatus) stsLow <= strb.statusVal;
      if (strb.orStatus) stsLow <= stsLow | strb.orVal;
      if (strb.awaitSet) awaitCmdBytes <= 1'b1;
      if (strb.awaitClr) awaitCmdBytes <= 1'b0;
      if (strb.chipRst) begin
        stsLow        <= '0;
        intReason     <= '0;
        seqStep       <= '0;
        irq           <= 1'b0;
        dmaMode       <= 1'b0;
        awaitCmdBytes <= 1'b0;
        cmdImage      <= '0;
      end
    end
  end

  p_dma_bit_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && !strb.chipRst |=> dmaMode == $past(cmdByte[REG_W-1]));
  p_reload_dma_r1: assert property (@(posedge clk) disable iff (!rstN)
    tcReload |-> dmaMode || chipRstPulse);
  p_chip_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    chipRstPulse |-> !irq && intReason == '0 && seqStep == '0 && !dmaMode && cmdImage == '0);
  p_bad_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    badCmd |-> $stable(intReason) && $stable(seqStep) && $stable(stsLow));
  p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(cmdWr));
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xferStart, chipRstPulse, fifoFlagsClr, badCmd}));
endmodule

// File: rtl/scsi_cmd_decoder.sv
module scsi_cmd_decoder
  import scsi_cmd_dec_pkg::*;
#(
  parameter int ID_W = 3,
  localparam int N_TGT = 1 << ID_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [REG_W-1:0] cmdByte,
  input  logic [ID_W-1:0]  busId,
  input  logic [N_TGT-1:0] targetPresent,
  input  logic             cfgBusRstQuiet,
  input  logic             irqAck,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] intReason,
  output logic [REG_W-1:0] seqStep,
  output logic             irq,
  output logic             dmaMode,
  output logic             tcReload,
  output logic             xferStart,
  output logic             chipRstPulse,
  output logic             fifoFlagsClr,
  output logic             badCmd,
  output logic             awaitCmdBytes,
  output logic [REG_W-1:0] cmdImage
);
  decStrobes_t strb;

  scsi_cmd_ctl #(.ID_W(ID_W)) u_ctl (
    .cmdWr(cmdWr), .opField(cmdByte[OP_W-1:0]), .busId(busId),
    .targetPresent(targetPresent), .cfgBusRstQuiet(cfgBusRstQuiet), .strb(strb)
  );

  scsi_cmd_dp u_dp (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdByte(cmdByte), .irqAck(irqAck),
    .strb(strb), .status(status), .intReason(intReason), .seqStep(seqStep),
    .irq(irq), .dmaMode(dmaMode), .tcReload(tcReload), .xferStart(xferStart),
    .chipRstPulse(chipRstPulse), .fifoFlagsClr(fifoFlagsClr), .badCmd(badCmd),
    .awaitCmdBytes(awaitCmdBytes), .cmdImage(cmdImage)
  );
endmodule

// File: tb/scsi_cmd_decoder_tb.sv
`timescale 1ns/1ps
module scsi_cmd_decoder_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWr = 1'b0;
  logic [7:0] cmdByte = '0;
  logic [2:0] busId = '0;
  logic [7:0] targetPresent = '0;
  logic cfgBusRstQuiet = 1'b0;
  logic irqAck = 1'b0;
  logic [7:0] status, intReason, seqStep, cmdImage;
  logic irq, dmaMode, tcReload, xferStart, chipRstPulse, fifoFlagsClr, badCmd, awaitCmdBytes;

  always #4 clk = ~clk;

  scsi_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdByte(cmdByte), .busId(busId),
    .targetPresent(targetPresent), .cfgBusRstQuiet(cfgBusRstQuiet), .irqAck(irqAck),
    .status(status), .intReason(intReason), .seqStep(seqStep), .irq(irq),
    .dmaMode(dmaMode), .tcReload(tcReload), .xferStart(xferStart),
    .chipRstPulse(chipRstPulse), .fifoFlagsClr(fifoFlagsClr), .badCmd(badCmd),
    .awaitCmdBytes(awaitCmdBytes), .cmdImage(cmdImage)
  );

  int total = 0;
  int bad = 0;
  string curTag = "reset";
  bit done = 0;

  // behavioural reference
  int mSts = 0, mReason = 0, mSeq = 0, mImg = 0;
  bit mIrq = 0, mDma = 0, mAwait = 0;
  bit mReload = 0, mXfer = 0, mChip = 0, mFifo = 0, mBad = 0;

  always @(posedge clk) begin
    mReload = 0; mXfer = 0; mChip = 0; mFifo = 0; mBad = 0;
    if (!rstN) begin
      mSts = 0; mReason = 0; mSeq = 0; mImg = 0; mIrq = 0; mDma = 0; mAwait = 0;
    end else begin
      bit raise;
      int op;
      raise = 0;
      if (cmdWr) begin
        op = cmdByte & 8'h7f;
        mImg = cmdByte;
        mDma = cmdByte[7];
        mReload = cmdByte[7];
        if (op == 8'h01) begin mReason = 8; mSeq = 0; mFifo = 1; end
        else if (op == 8'h02) begin
          mChip = 1; mSts = 0; mReason = 0; mSeq = 0; mImg = 0; mDma = 0; mAwait = 0;
        end
        else if (op == 8'h03) begin mReason = 128; raise = !cfgBusRstQuiet; end
        else if (op == 8'h10) begin mXfer = 1; mAwait = 0; end
        else if (op == 8'h11) begin mReason = 8; mSts = mSts | 7; raise = 1; end
        else if (op == 8'h12) begin mReason = 32; mSeq = 0; raise = 1; end
        else if (op == 8'h42 || op == 8'h43) begin
          raise = 1;
          if (targetPresent[busId] == 1'b0) begin mSts = 0; mReason = 32; mSeq = 0; end
          else begin
            mReason = 24; mSeq = 4;
            if (op == 8'h43) begin mSts = 18; mAwait = 1; end
          end
        end
        else if (op == 8'h44) mReason = 0;
        else if (op == 8'h00 || op == 8'h1a) ;
        else mBad = 1;
      end
      if (irqAck) mIrq = 0;
      if (raise) mIrq = 1;
      if (mChip) mIrq = 0;
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] expSts;
      logic [31:0] act, exp;
      expSts = {mIrq, 7'(mSts)};
      act = {status, intReason, seqStep, cmdImage};
      exp = {expSts, 8'(mReason), 8'(mSeq), 8'(mImg)};
      total++;
      if (act != exp ||
          {irq, dmaMode, awaitCmdBytes, tcReload, xferStart, chipRstPulse, fifoFlagsClr, badCmd} !=
          {mIrq, mDma, mAwait, mReload, mXfer, mChip, mFifo, mBad}) begin
        bad++;
        $display("FAIL %s: regs act=%h exp=%h flags act=%b exp=%b", curTag, act, exp,
          {irq, dmaMode, awaitCmdBytes, tcReload, xferStart, chipRstPulse, fifoFlagsClr, badCmd},
          {mIrq, mDma, mAwait, mReload, mXfer, mChip, mFifo, mBad});
      end
    end
  end

  task automatic wr(input logic [7:0] c, input logic [2:0] id, input logic [7:0] pres,
                    input logic quiet, input logic ack, input string tag);
    curTag = tag;
    cmdByte = c; busId = id; targetPresent = pres; cfgBusRstQuiet = quiet;
    irqAck = ack; cmdWr = 1'b1;
    @(negedge clk);
    cmdWr = 1'b0; irqAck = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack(input string tag);
    curTag = tag;
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    wr(8'h80, 0, 8'h00, 0, 0, "R1 dma nop");
    wr(8'h00, 0, 8'h00, 0, 0, "R1 dma clear / R10 nop");
    wr(8'h03, 0, 8'h00, 0, 0, "R4 bus reset loud");
    ack("R12 ack alone");
    wr(8'h03, 0, 8'h00, 1, 0, "R4 bus reset quiet");
    wr(8'h42, 3, 8'h08, 0, 0, "R6 select present");
    wr(8'h01, 0, 8'h00, 0, 0, "R2 flush");
    wr(8'h01, 0, 8'h00, 0, 1, "R12 ack with flush");
    wr(8'h43, 1, 8'h02, 0, 0, "R7 select stop");
    wr(8'h90, 0, 8'h00, 0, 0, "R8 transfer dma");
    wr(8'h42, 5, 8'hdf, 0, 0, "R5 select absent");
    wr(8'h43, 3, 8'h08, 0, 0, "R7 select stop again");
    wr(8'hc3, 7, 8'h7f, 0, 0, "R5 select stop absent");
    wr(8'h11, 0, 8'h00, 0, 1, "R9 complete seq with ack / R12");
    wr(8'h12, 0, 8'h00, 0, 0, "R9 message accepted");
    wr(8'h44, 0, 8'h00, 0, 0, "R10 enable selection");
    wr(8'h1a, 0, 8'h00, 0, 0, "R10 set atn");
    wr(8'h7f, 0, 8'h00, 0, 0, "R11 unknown 7f");
    wr(8'ha0, 0, 8'h00, 0, 0, "R11 unknown a0 / R13");
    wr(8'h43, 2, 8'h04, 0, 0, "R7 before reset");
    wr(8'h82, 0, 8'h00, 0, 0, "R3 chip reset dma");
    wr(8'h5c, 0, 8'h00, 0, 0, "R13 image");
    wr(8'h02, 0, 8'h00, 0, 0, "R3 chip reset");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule